// File: doc/BRIEF.md
# Synchronous Dual-Port Memory Port Controller

This block is an 8-bit-wide memory with two independent clocked ports, left and right. Each port has its own clock, address, data in, and control inputs, and every port can read or write any word. The two ports can access the same word on the same clock edge.

Each port takes its access address from its own address unit. On a clock edge the address unit loads an external address, steps to the next word, holds its value, or clears to word zero. The unit updates on every edge, whether or not the port is selected.

Read data leaves the port on a data bus with a valid flag, which replaces a high-impedance pin. A static input on each port picks the output timing:

- **Flow-through:** data for the access appears in the cycle right after the edge.
- **Pipelined:** data appears one cycle later.

A small per-port state machine tracks how many edges in a row the port has been selected. It has three states:

- **PO_OFF:** the port was deselected at the last edge.
- **PO_WAKE:** the port has been selected for one edge.
- **PO_ON:** the port has been selected for two or more edges.

Its transitions are:

- Any deselected edge goes to PO_OFF.
- A selected edge moves PO_OFF to PO_WAKE, PO_WAKE to PO_ON, and keeps PO_ON in PO_ON.

The output enable is asynchronous and can blank the output at any moment.

Top module: `dpm_sync_dual`

## Requirements
- R1: A port is selected only when `cs0_n`=0 and `cs1`=1. Any other pair blocks writing on that edge and leaves `dout_vld` low after it.
- R2: On a selected edge with `we_n`=0, `din` is stored at the port's access address.
- R3: In flow-through mode (`pipe`=0), a selected edge with `we_n`=1 makes `dout_vld` high and puts the stored byte on `dout` until the next edge.
- R4: In pipelined mode (`pipe`=1), data read at edge k is driven after edge k+1, provided the port is still selected at k+1. A write at edge k gives no valid output after k+1.
- R5: In pipelined mode, after a deselected edge the port must be selected for two edges before `dout_vld` rises again.
- R6: `oe_n`=1 forces `dout_vld` low at once, with no clock edge needed. Returning `oe_n` to 0 restores the clocked output state.
- R7: The access address has a fixed priority:
  - `zero_n`=0 selects word 0.
  - Otherwise, `strobe_n`=0 selects `addr`.
  - Otherwise, `step_n`=0 selects the previous address plus one, wrapping at the top word.
  - Otherwise, the previous address is used again.
  
  The address unit updates on every edge, whatever the chip enables are.
- R8: When one port writes a word on the same edge that the other port reads it, the read returns the value stored before the write.
- R9: When both ports write the same word on the same edge, the left port's byte is kept.
- R10: In flow-through mode, a write edge leaves `dout_vld` low until the next edge.
- R11: While `rst_n` is low, both `dout_vld` outputs are low and both address units hold word 0.
- R12: Every word written through either port can be read back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both ports |
| l_clk | input | 1 | Left port clock |
| l_cs0_n | input | 1 | Left chip enable, active low |
| l_cs1 | input | 1 | Left chip enable, active high |
| l_we_n | input | 1 | Left write select: 0 writes, 1 reads |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_pipe | input | 1 | Left output mode: 1 pipelined, 0 flow-through |
| l_addr | input | ADDR_W | Left external address |
| l_strobe_n | input | 1 | Left address load, active low |
| l_step_n | input | 1 | Left address advance, active low |
| l_zero_n | input | 1 | Left address clear, active low |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data |
| l_dout_vld | output | 1 | Left read data valid |
| r_clk | input | 1 | Right port clock |
| r_cs0_n | input | 1 | Right chip enable, active low |
| r_cs1 | input | 1 | Right chip enable, active high |
| r_we_n | input | 1 | Right write select: 0 writes, 1 reads |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_pipe | input | 1 | Right output mode: 1 pipelined, 0 flow-through |
| r_addr | input | ADDR_W | Right external address |
| r_strobe_n | input | 1 | Right address load, active low |
| r_step_n | input | 1 | Right address advance, active low |
| r_zero_n | input | 1 | Right address clear, active low |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data |
| r_dout_vld | output | 1 | Right read data valid |

## Verification
The assertions check, on every cycle, the timing of the valid flag:

- it stays low after deselected edges;
- it tracks the output enable after a flow-through read;
- it stays low after a flow-through write;
- it stays low after a pipelined write;
- it stays low through the first selected edge after a deselect in pipelined mode.

Only the bench scenarios can show that the data values are correct. These cover:

- the stored contents of every word, read back across ports;
- the address unit's wrap and its priority order;
- the old-value result of a cross-port read-during-write;
- left-port priority on a double write.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    // Output state of one port, following how long it has been selected
    typedef enum logic [1:0] {
        PO_OFF  = 2'd0,
        PO_WAKE = 2'd1,
        PO_ON   = 2'd2
    } po_state_t;
endpackage

// File: rtl/dpm_addr_unit.sv
module dpm_addr_unit #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              zero_n,
    output logic [ADDR_W-1:0] acc_addr
);
    logic [ADDR_W-1:0] cnt_q;

    // Priority: clear, load, advance, hold
    always_comb begin
        if (!zero_n)
            acc_addr = '0;
        else if (!strobe_n)
            acc_addr = ext_addr;
        else if (!step_n)
            acc_addr = cnt_q + ADDR_W'(1);
        else
            acc_addr = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= acc_addr;
    end
endmodule

// File: rtl/dpm_out_ctl.sv
module dpm_out_ctl
    import dpm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd_req,
    input  logic              pipe,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    po_state_t         state_q, state_d;
    logic              rd_q1, rd_q2;
    logic [DATA_W-1:0] data_q1, data_q2;
    logic              drive;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PO_OFF:  state_d = sel ? PO_WAKE : PO_OFF;
            PO_WAKE: state_d = sel ? PO_ON   : PO_OFF;
            PO_ON:   state_d = sel ? PO_ON   : PO_OFF;
            default: state_d = PO_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PO_OFF;
            rd_q1   <= 1'b0;
            rd_q2   <= 1'b0;
            data_q1 <= '0;
            data_q2 <= '0;
        end else begin
            state_q <= state_d;
            rd_q1   <= rd_req;
            rd_q2   <= rd_q1;
            data_q1 <= rd_word;
            data_q2 <= data_q1;
        end
    end

    // Clocked drive decision per state; the output enable masks it asynchronously
    always_comb begin
        drive = 1'b0;
        unique case (state_q)
            PO_OFF:  drive = 1'b0;
            PO_WAKE: drive = !pipe && rd_q1;
            PO_ON:   drive = pipe ? rd_q2 : rd_q1;
            default: drive = 1'b0;
        endcase
        dout_vld = drive && !oe_n;
        dout     = dout_vld ? (pipe ? data_q2 : data_q1) : '0;
    end
endmodule

// File: rtl/dpm_sync_dual.sv
module dpm_sync_dual #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              rst_n,
    input  logic              l_clk,
    input  logic              l_cs0_n,
    input  logic              l_cs1,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_strobe_n,
    input  logic              l_step_n,
    input  logic              l_zero_n,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_dout_vld,
    input  logic              r_clk,
    input  logic              r_cs0_n,
    input  logic              r_cs1,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_strobe_n,
    input  logic              r_step_n,
    input  logic              r_zero_n,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_dout_vld
);
    localparam int DEPTH = 1 << ADDR_W;

    // One bank per writer; a word's value is the XOR of both banks
    logic [DATA_W-1:0] bank_l [DEPTH];
    logic [DATA_W-1:0] bank_r [DEPTH];

    logic [ADDR_W-1:0] l_acc, r_acc;
    logic              l_sel, r_sel, l_wr, r_wr, r_blocked;
    logic [DATA_W-1:0] l_word, r_word;

    assign l_sel = !l_cs0_n && l_cs1;
    assign r_sel = !r_cs0_n && r_cs1;
    assign l_wr  = l_sel && !l_we_n;
    assign r_wr  = r_sel && !r_we_n;
    assign r_blocked = l_wr && (l_acc == r_acc);

    dpm_addr_unit #(.ADDR_W(ADDR_W)) u_addr_l (
        .clk(l_clk), .rst_n(rst_n), .ext_addr(l_addr), .strobe_n(l_strobe_n),
        .step_n(l_step_n), .zero_n(l_zero_n), .acc_addr(l_acc)
    );
    dpm_addr_unit #(.ADDR_W(ADDR_W)) u_addr_r (
        .clk(r_clk), .rst_n(rst_n), .ext_addr(r_addr), .strobe_n(r_strobe_n),
        .step_n(r_step_n), .zero_n(r_zero_n), .acc_addr(r_acc)
    );

    always_ff @(posedge l_clk) begin
        if (l_wr)
            bank_l[l_acc] <= l_din ^ bank_r[l_acc];
    end

    // Right write yields to a left write of the same word on the same edge
    always_ff @(posedge r_clk) begin
        if (r_wr && !r_blocked)
            bank_r[r_acc] <= r_din ^ bank_l[r_acc];
    end

    assign l_word = bank_l[l_acc] ^ bank_r[l_acc];
    assign r_word = bank_l[r_acc] ^ bank_r[r_acc];

    dpm_out_ctl #(.DATA_W(DATA_W)) u_out_l (
        .clk(l_clk), .rst_n(rst_n), .sel(l_sel), .rd_req(l_sel && l_we_n),
        .pipe(l_pipe), .oe_n(l_oe_n), .rd_word(l_word),
        .dout(l_dout), .dout_vld(l_dout_vld)
    );
    dpm_out_ctl #(.DATA_W(DATA_W)) u_out_r (
        .clk(r_clk), .rst_n(rst_n), .sel(r_sel), .rd_req(r_sel && r_we_n),
        .pipe(r_pipe), .oe_n(r_oe_n), .rd_word(r_word),
        .dout(r_dout), .dout_vld(r_dout_vld)
    );
endmodule

// File: rtl/dpm_sync_dual_chk.sv
module dpm_sync_dual_chk (
    input logic rst_n,
    input logic l_clk,
    input logic l_cs0_n,
    input logic l_cs1,
    input logic l_we_n,
    input logic l_oe_n,
    input logic l_pipe,
    input logic l_dout_vld,
    input logic r_clk,
    input logic r_cs0_n,
    input logic r_cs1,
    input logic r_we_n,
    input logic r_pipe,
    input logic r_dout_vld
);
    logic l_on, r_on;
    assign l_on = !l_cs0_n && l_cs1;
    assign r_on = !r_cs0_n && r_cs1;

    AST_DESEL_QUIET_L: assert property (@(posedge l_clk) disable iff (!rst_n) !l_on |=> !l_dout_vld); // R1
    AST_DESEL_QUIET_R: assert property (@(posedge r_clk) disable iff (!rst_n) !r_on |=> !r_dout_vld); // R1
    AST_FLOW_READ_L: assert property (@(posedge l_clk) disable iff (!rst_n) (!l_pipe && l_on && l_we_n) |=> (l_dout_vld == !l_oe_n)); // R3
    AST_FLOW_WRITE_L: assert property (@(posedge l_clk) disable iff (!rst_n) (!l_pipe && l_on && !l_we_n) |=> !l_dout_vld); // R10
    AST_PIPE_WAKE_R: assert property (@(posedge r_clk) disable iff (!rst_n) (r_pipe && !r_on) |=> ##1 (!r_dout_vld || !r_pipe)); // R5
    AST_PIPE_WRITE_R: assert property (@(posedge r_clk) disable iff (!rst_n) (r_pipe && r_on && !r_we_n) |=> ##1 (!r_dout_vld || !r_pipe)); // R4
endmodule

bind dpm_sync_dual dpm_sync_dual_chk u_chk (
    .rst_n(rst_n), .l_clk(l_clk), .l_cs0_n(l_cs0_n), .l_cs1(l_cs1), .l_we_n(l_we_n),
    .l_oe_n(l_oe_n), .l_pipe(l_pipe), .l_dout_vld(l_dout_vld), .r_clk(r_clk),
    .r_cs0_n(r_cs0_n), .r_cs1(r_cs1), .r_we_n(r_we_n), .r_pipe(r_pipe),
    .r_dout_vld(r_dout_vld)
);

// File: tb/dpm_sync_dual_test.sv
module dpm_sync_dual_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_cs0_n = 1'b1, l_cs1 = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b0, l_pipe = 1'b0;
    logic l_strobe_n = 1'b1, l_step_n = 1'b1, l_zero_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [7:0] l_din = '0;
    logic r_cs0_n = 1'b1, r_cs1 = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b0, r_pipe = 1'b0;
    logic r_strobe_n = 1'b1, r_step_n = 1'b1, r_zero_n = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [7:0] r_din = '0;
    logic [7:0] l_dout, r_dout;
    logic l_dout_vld, r_dout_vld;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ref_mem [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpm_sync_dual #(.ADDR_W(AW), .DATA_W(8)) uut (
        .rst_n(rst_n),
        .l_clk(clk), .l_cs0_n(l_cs0_n), .l_cs1(l_cs1), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
        .l_pipe(l_pipe), .l_addr(l_addr), .l_strobe_n(l_strobe_n), .l_step_n(l_step_n),
        .l_zero_n(l_zero_n), .l_din(l_din), .l_dout(l_dout), .l_dout_vld(l_dout_vld),
        .r_clk(clk), .r_cs0_n(r_cs0_n), .r_cs1(r_cs1), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
        .r_pipe(r_pipe), .r_addr(r_addr), .r_strobe_n(r_strobe_n), .r_step_n(r_step_n),
        .r_zero_n(r_zero_n), .r_din(r_din), .r_dout(r_dout), .r_dout_vld(r_dout_vld)
    );

    function automatic logic [7:0] pat(input int a, input int s);
        return 8'(a * 37 + s * 11 + 3);
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic got_v, input logic exp_v,
                         input logic [7:0] got_d, input logic [7:0] exp_d);
        n_cmp++;
        if (got_v !== exp_v || (exp_v && got_d !== exp_d)) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b data=%02h, expected vld=%0b data=%02h",
                     req, got_v, got_d, exp_v, exp_d);
        end
    endtask

    task automatic l_op(input logic sel, input logic wr, input int a, input logic [7:0] d);
        l_cs0_n = !sel; l_cs1 = 1'b1; l_we_n = !wr; l_strobe_n = 1'b0;
        l_step_n = 1'b1; l_zero_n = 1'b1; l_addr = AW'(a); l_din = d;
    endtask

    task automatic r_op(input logic sel, input logic wr, input int a, input logic [7:0] d);
        r_cs0_n = !sel; r_cs1 = 1'b1; r_we_n = !wr; r_strobe_n = 1'b0;
        r_step_n = 1'b1; r_zero_n = 1'b1; r_addr = AW'(a); r_din = d;
    endtask

    initial begin
        #(CLK_PERIOD * 4000);
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] old_v;
        // R11: reset state
        tick; tick;
        check("R11 left reset", l_dout_vld, 1'b0, l_dout, 8'h00);
        check("R11 right reset", r_dout_vld, 1'b0, r_dout, 8'h00);
        rst_n = 1'b1;
        tick;
        // R11: address unit starts at word 0 (hold selects previous address)
        l_op(1, 1, 0, 8'h5A); l_strobe_n = 1'b1; tick; ref_mem[0] = 8'h5A;
        l_op(1, 0, 0, 8'h00); l_strobe_n = 1'b1; tick;
        check("R11 counter at zero", l_dout_vld, 1'b1, l_dout, 8'h5A);

        // R2/R12: left fills every word, right then reads each back flow-through (R3)
        for (int a = 0; a < NW; a++) begin
            l_op(1, 1, a, pat(a, 1)); tick; ref_mem[a] = pat(a, 1);
        end
        l_op(0, 0, 0, 8'h00);
        for (int a = 0; a < NW; a++) begin
            r_op(1, 0, a, 8'h00);
            l_op(1, 0, NW - 1 - a, 8'h00);
            tick;
            check("R12 right reads left data", r_dout_vld, 1'b1, r_dout, ref_mem[a]);
            check("R3 left flow read", l_dout_vld, 1'b1, l_dout, ref_mem[NW - 1 - a]);
        end
        // R2: right writes every word, left reads back
        for (int a = 0; a < NW; a++) begin
            r_op(1, 1, a, pat(a, 2)); l_op(0, 0, 0, 8'h00); tick; ref_mem[a] = pat(a, 2);
        end
        r_op(0, 0, 0, 8'h00);
        for (int a = 0; a < NW; a++) begin
            l_op(1, 0, a, 8'h00); tick;
            check("R2 right write seen on left", l_dout_vld, 1'b1, l_dout, ref_mem[a]);
        end

        // R10: flow write edge gives no valid output
        l_op(1, 1, 3, pat(3, 9)); tick; ref_mem[3] = pat(3, 9);
        check("R10 flow write quiet", l_dout_vld, 1'b0, l_dout, 8'h00);

        // R7: address unit load, step with wrap, hold, clear priority
        l_op(1, 0, 14, 8'h00); tick;
        check("R7 load 14", l_dout_vld, 1'b1, l_dout, ref_mem[14]);
        l_strobe_n = 1'b1; l_step_n = 1'b0;
        tick; check("R7 step to 15", l_dout_vld, 1'b1, l_dout, ref_mem[15]);
        tick; check("R7 wrap to 0", l_dout_vld, 1'b1, l_dout, ref_mem[0]);
        tick; check("R7 step to 1", l_dout_vld, 1'b1, l_dout, ref_mem[1]);
        l_step_n = 1'b1;
        tick; check("R7 hold at 1", l_dout_vld, 1'b1, l_dout, ref_mem[1]);
        l_zero_n = 1'b0; l_strobe_n = 1'b0; l_addr = AW'(7);
        tick; check("R7 clear beats load", l_dout_vld, 1'b1, l_dout, ref_mem[0]);
        l_zero_n = 1'b1; l_strobe_n = 1'b1; l_step_n = 1'b0; l_cs0_n = 1'b1;
        tick; check("R1 deselected step", l_dout_vld, 1'b0, l_dout, 8'h00);
        tick;
        l_cs0_n = 1'b0; l_step_n = 1'b1;
        tick; check("R7 steps while deselected", l_dout_vld, 1'b1, l_dout, ref_mem[2]);

        // R1: every chip-enable pair, reads then blocked writes
        for (int c = 0; c < 4; c++) begin
            l_op(1, 0, 6, 8'h00); l_cs0_n = c[1]; l_cs1 = c[0]; tick;
            check("R1 select decode", l_dout_vld, (c == 1), l_dout, ref_mem[6]);
        end
        for (int c = 0; c < 4; c++) begin
            if (c != 1) begin
                l_op(1, 1, 6, 8'hA5); l_cs0_n = c[1]; l_cs1 = c[0]; tick;
            end
        end
        l_op(1, 0, 6, 8'h00); tick;
        check("R1 deselected write blocked", l_dout_vld, 1'b1, l_dout, ref_mem[6]);

        // R6: asynchronous output enable
        l_op(1, 0, 2, 8'h00); tick;
        check("R6 before disable", l_dout_vld, 1'b1, l_dout, ref_mem[2]);
        l_oe_n = 1'b1; #1;
        check("R6 disabled at once", l_dout_vld, 1'b0, l_dout, 8'h00);
        l_oe_n = 1'b0; #1;
        check("R6 re-enabled", l_dout_vld, 1'b1, l_dout, ref_mem[2]);
        l_op(0, 0, 0, 8'h00);

        // R4/R5: right pipelined sweep
        r_op(0, 0, 0, 8'h00); r_pipe = 1'b1; tick; tick;
        for (int a = 0; a < NW; a++) begin
            r_op(1, 0, a, 8'h00); tick;
            check("R4 pipelined sweep / R5 first edge", r_dout_vld, (a > 0), r_dout,
                  ref_mem[(a + NW - 1) % NW]);
        end
        r_op(0, 0, 0, 8'h00); tick;
        check("R1 pipelined deselect", r_dout_vld, 1'b0, r_dout, 8'h00);
        r_op(1, 0, 8, 8'h00); tick;
        check("R5 one selected edge", r_dout_vld, 1'b0, r_dout, 8'h00);
        r_op(1, 0, 9, 8'h00); tick;
        check("R5 two selected edges", r_dout_vld, 1'b1, r_dout, ref_mem[8]);
        r_op(1, 1, 10, pat(10, 4)); tick;
        check("R4 read shows during write", r_dout_vld, 1'b1, r_dout, ref_mem[9]);
        ref_mem[10] = pat(10, 4);
        r_op(1, 0, 11, 8'h00); tick;
        check("R4 write gives no data", r_dout_vld, 1'b0, r_dout, 8'h00);
        r_op(1, 0, 12, 8'h00); tick;
        check("R4 resumes", r_dout_vld, 1'b1, r_dout, ref_mem[11]);
        r_op(0, 0, 0, 8'h00); tick; r_pipe = 1'b0; tick; tick;

        // R8: cross-port read during write returns old value
        old_v = ref_mem[5];
        l_op(1, 1, 5, pat(5, 7)); r_op(1, 0, 5, 8'h00); tick;
        check("R8 old data on collision", r_dout_vld, 1'b1, r_dout, old_v);
        ref_mem[5] = pat(5, 7);
        l_op(0, 0, 0, 8'h00); tick;
        check("R8 new data next edge", r_dout_vld, 1'b1, r_dout, ref_mem[5]);

        // R9: double write, left kept
        l_op(1, 1, 9, 8'h3C); r_op(1, 1, 9, 8'hC3); tick; ref_mem[9] = 8'h3C;
        l_op(0, 0, 0, 8'h00); r_op(1, 0, 9, 8'h00); tick;
        check("R9 left priority", r_dout_vld, 1'b1, r_dout, ref_mem[9]);
        // R12: simultaneous writes to different words both land
        l_op(1, 1, 10, 8'h11); r_op(1, 1, 11, 8'h22); tick;
        ref_mem[10] = 8'h11; ref_mem[11] = 8'h22;
        l_op(1, 0, 11, 8'h00); r_op(1, 0, 10, 8'h00); tick;
        check("R12 left sees right word", l_dout_vld, 1'b1, l_dout, ref_mem[11]);
        check("R12 right sees left word", r_dout_vld, 1'b1, r_dout, ref_mem[10]);
        l_op(0, 0, 0, 8'h00); r_op(0, 0, 0, 8'h00); tick;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule